// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This block is a small register-mapped performance monitor that sits beside a memory controller. It holds four event counters. Each counter has a control register with an enable bit, a clear bit, an overflow flag and an 8-bit event selector. The counter values are read back through a separate set of read-only offsets. The memory controller reports its events as single-cycle pulses on a wide input vector, and each bit of that vector belongs to one event code.

Counter 0 is a dedicated clock-cycle counter. Its enable bit is also the global run gate for the whole unit. When counter 0 wraps, every counter freezes and the interrupt output rises. The other counters wrap without any interrupt, so software can compute deltas modulo the counter width.

Two event codes count AXI read and AXI write transactions. They pass only when the transaction ID matches a shared filter register under a mask. All other codes ignore the filter. Software reads the registers over a simple 32-bit read/write bus with one cycle of read latency.

Top module: `mc_perf_unit`

## Requirements
- R1: After reset, every control register, counter value and the filter register read 0, and irq is 0.
- R2: Control register n sits at byte offset 0x00+4n. Counter n's value is read at 0x20+4n, zero-extended to 32 bits. The filter register is at 0x30. In a control register, bit 0 is the overflow flag, bit 1 is clear (write-only, reads 0), bit 2 is enable, and bits 31:24 are the event code. A read returns its data on busRdata one cycle after busRe.
- R3: While counter 0's enable is set and its overflow flag is clear, counter 0 adds one on every clock, whatever its event code.
- R4: Counters 1 to 3 add one for each clock in which the pulse of their selected code is high, provided their own enable and the global run condition of R3 both hold. Event code 0x00, and any code outside the event vector, counts nothing on these counters. A disabled counter does not count.
- R5: A control write with the clear bit set zeroes that counter in the write cycle, so counting starts from 0 when enable is written together with clear.
- R6: While counter 0's enable is 0, no counter changes except by clear. Writing enable to counter 0 again, without clear, resumes every counter from its held value.
- R7: When counter 1, 2 or 3 steps from all ones, it wraps to zero and keeps counting. Its overflow flag (bit 0) is set, and irq stays 0.
- R8: When counter 0 steps from all ones to zero, its overflow flag is set and irq follows that flag. From the next clock on, every counter holds its value. Any write to control register 0 clears the flag, which drops irq.
- R9: Filter bits 15:0 hold an ID. In bits 31:16, a 0 bit marks the matching ID bit as compared and a 1 bit marks it as don't-care. Code 0x41 counts a pulse only when rdId passes this filter, and code 0x42 only when wrId passes.
- R10: Every code other than 0x41 and 0x42 counts regardless of the filter and of rdId or wrId.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busAddr | input | ADDR_W (8) | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid one cycle after busRe |
| evtPulse | input | 2**EVT_W (256) | One-cycle event pulses, bit index = event code |
| rdId | input | ID_W (16) | ID of the AXI read whose pulse is on code 0x41 |
| wrId | input | ID_W (16) | ID of the AXI write whose pulse is on code 0x42 |
| irq | output | 1 | Cycle-counter overflow interrupt |

## Verification
The cycle counter is run for exact windows and then resumed without clear. This separates true holding from a reload. The event counters get isolated pulses on selected, unselected, zero and disabled codes, and then a burst while the global gate is off, which tells a per-counter enable apart from the global run gate. The filter is tried with IDs that differ only in compared bits, only in don't-care bits, and with an all-don't-care mask, and an unfiltered code is driven with mismatching IDs. The overflow paths are reached by running the narrowed bench configuration long enough to wrap. One run wraps an event counter while the cycle counter is periodically cleared, and another wraps the cycle counter under an alternating event stream, to show silent wrap versus freeze and interrupt.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int MPU_NCTR = 4;
  localparam int MPU_BUSW = 32;
  localparam int MPU_CODEW = 8;

  localparam int BIT_OVF = 0;
  localparam int BIT_CLR = 1;
  localparam int BIT_EN = 2;
  localparam int CODE_LSB = 24;
  localparam int FILT_MASK_LSB = 16;

  localparam logic [MPU_CODEW-1:0] EVT_CYCLES = 8'h00;
  localparam logic [MPU_CODEW-1:0] EVT_AXI_RD = 8'h41;
  localparam logic [MPU_CODEW-1:0] EVT_AXI_WR = 8'h42;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_CNT = 'h20;
  localparam int OFS_FILT = 'h30;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic [MPU_NCTR-1:0] enable;
    logic [MPU_NCTR-1:0] clear;
  } mpuStrobe_t;
endpackage

// File: rtl/mpu_ctrl.sv
module mpu_ctrl
  import mpu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ID_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWe,
  input  logic busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [MPU_BUSW-1:0] busWdata,
  output logic [MPU_BUSW-1:0] busRdata,
  input  logic [MPU_NCTR-1:0] wrapHit,
  input  logic [MPU_NCTR*CNT_W-1:0] cntFlat,
  output mpuStrobe_t strobe,
  output logic [MPU_NCTR*MPU_CODEW-1:0] codeFlat,
  output logic [ID_W-1:0] filtId,
  output logic [ID_W-1:0] filtMask,
  output logic irq
);
  localparam int NC = MPU_NCTR;

  logic [NC-1:0] enReg;
  logic [NC-1:0] ovfReg;
  logic [NC-1:0] ctrlSel;
  logic [MPU_CODEW-1:0] codeReg [NC];
  logic filtSel;
  logic [MPU_BUSW-1:0] rdMux;
  logic unusedBits;

  assign unusedBits = ^{busWdata[CODE_LSB-1:BIT_EN+1], busWdata[BIT_OVF]};

  always_comb begin
    for (int n = 0; n < NC; n++) begin
      ctrlSel[n] = busWe && (busAddr == ADDR_W'(OFS_CTRL + 4 * n));
    end
    filtSel = busWe && (busAddr == ADDR_W'(OFS_FILT));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
      ovfReg <= '0;
      idReg_clear();
    end else begin
      for (int n = 0; n < NC; n++) begin
        if (ctrlSel[n]) begin
          enReg[n] <= busWdata[BIT_EN];
          codeReg[n] <= busWdata[CODE_LSB +: MPU_CODEW];
          ovfReg[n] <= 1'b0;
        end
        if (wrapHit[n]) ovfReg[n] <= 1'b1;
      end
      if (filtSel) begin
        filtId <= busWdata[ID_W-1:0];
        filtMask <= busWdata[FILT_MASK_LSB +: ID_W];
      end
    end
  end

  // reset of code and filter storage, kept apart for readability
  task automatic idReg_clear();
    for (int n = 0; n < NC; n++) codeReg[n] <= '0;
    filtId <= '0;
    filtMask <= '0;
  endtask

  always_comb begin
    for (int n = 0; n < NC; n++) codeFlat[n*MPU_CODEW +: MPU_CODEW] = codeReg[n];
    strobe.enable = enReg;
    strobe.clear = ctrlSel & {NC{busWdata[BIT_CLR]}};
    strobe.run = enReg[0] & ~ovfReg[0];
  end

  assign irq = ovfReg[0];

  always_comb begin
    rdMux = '0;
    for (int n = 0; n < NC; n++) begin
      if (busAddr == ADDR_W'(OFS_CTRL + 4 * n)) begin
        rdMux[CODE_LSB +: MPU_CODEW] = codeReg[n];
        rdMux[BIT_EN] = enReg[n];
        rdMux[BIT_OVF] = ovfReg[n];
      end
      if (busAddr == ADDR_W'(OFS_CNT + 4 * n)) begin
        rdMux = MPU_BUSW'(cntFlat[n*CNT_W +: CNT_W]);
      end
    end
    if (busAddr == ADDR_W'(OFS_FILT)) begin
      rdMux[ID_W-1:0] = filtId;
      rdMux[FILT_MASK_LSB +: ID_W] = filtMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else if (busRe) busRdata <= rdMux;
  end
endmodule

// File: rtl/mpu_datapath.sv
module mpu_datapath
  import mpu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int EVT_W = 8,
  parameter int ID_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  mpuStrobe_t strobe,
  input  logic [MPU_NCTR*MPU_CODEW-1:0] codeFlat,
  input  logic [ID_W-1:0] filtId,
  input  logic [ID_W-1:0] filtMask,
  input  logic [(2**EVT_W)-1:0] evtPulse,
  input  logic [ID_W-1:0] rdId,
  input  logic [ID_W-1:0] wrId,
  output logic [MPU_NCTR*CNT_W-1:0] cntFlat,
  output logic [MPU_NCTR-1:0] wrapHit
);
  localparam int NUM_EVT = 2 ** EVT_W;

  logic rdPass;
  logic wrPass;

  // a 1 in the stored mask field marks a don't-care ID bit
  assign rdPass = ((rdId ^ filtId) & ~filtMask) == '0;
  assign wrPass = ((wrId ^ filtId) & ~filtMask) == '0;

  for (genvar n = 0; n < MPU_NCTR; n++) begin : gCnt
    logic [MPU_CODEW-1:0] code;
    logic hit;
    logic inc;
    logic [CNT_W-1:0] cntQ;

    assign code = codeFlat[n*MPU_CODEW +: MPU_CODEW];

    if (n == 0) begin : gCycle
      logic unusedCode;
      assign unusedCode = ^code;
      assign hit = 1'b1;
    end else begin : gEvent
      always_comb begin
        hit = 1'b0;
        if (code != EVT_CYCLES && int'(code) < NUM_EVT) begin
          hit = evtPulse[code[EVT_W-1:0]];
          if (code == EVT_AXI_RD) hit = hit & rdPass;
          if (code == EVT_AXI_WR) hit = hit & wrPass;
        end
      end
    end

    assign inc = strobe.run & strobe.enable[n] & hit;

    always_ff @(posedge clk) begin
      if (!rstN) cntQ <= '0;
      else if (strobe.clear[n]) cntQ <= '0;
      else if (inc) cntQ <= cntQ + 1'b1;
    end

    assign wrapHit[n] = inc & ~strobe.clear[n] & (cntQ == '1);
    assign cntFlat[n*CNT_W +: CNT_W] = cntQ;
  end
endmodule

// File: rtl/mc_perf_unit.sv
module mc_perf_unit
  import mpu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int EVT_W = 8,
  parameter int ID_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWe,
  input  logic busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [(2**EVT_W)-1:0] evtPulse,
  input  logic [ID_W-1:0] rdId,
  input  logic [ID_W-1:0] wrId,
  output logic irq
);
  mpuStrobe_t strobe;
  logic [MPU_NCTR*MPU_CODEW-1:0] codeFlat;
  logic [MPU_NCTR*CNT_W-1:0] cntFlat;
  logic [MPU_NCTR-1:0] wrapHit;
  logic [ID_W-1:0] filtId;
  logic [ID_W-1:0] filtMask;
  logic cycEn;

  assign cycEn = strobe.enable[0];

  mpu_ctrl #(.CNT_W(CNT_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wrapHit(wrapHit), .cntFlat(cntFlat),
    .strobe(strobe), .codeFlat(codeFlat), .filtId(filtId), .filtMask(filtMask), .irq(irq)
  );

  mpu_datapath #(.CNT_W(CNT_W), .EVT_W(EVT_W), .ID_W(ID_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .codeFlat(codeFlat), .filtId(filtId),
    .filtMask(filtMask), .evtPulse(evtPulse), .rdId(rdId), .wrId(wrId),
    .cntFlat(cntFlat), .wrapHit(wrapHit)
  );
endmodule

// File: rtl/mpu_checker.sv
module mpu_checker #(
  parameter int CNT_W = 32,
  parameter int ADDR_W = 8,
  parameter int NC = 4
) (
  input logic clk,
  input logic rstN,
  input logic irq,
  input logic busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0] busWdata,
  input logic [NC*CNT_W-1:0] cntFlat,
  input logic cycEn
);
  logic [CNT_W-1:0] cnt0;
  logic ctrl0ClrWr;
  logic unusedW;

  assign cnt0 = cntFlat[CNT_W-1:0];
  assign ctrl0ClrWr = busWe && (busAddr == '0) && busWdata[1];
  assign unusedW = ^{busWdata[31:2], busWdata[0]};

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    cycEn && !irq && !busWe |=> cnt0 == $past(cnt0) + 1'b1);  // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrl0ClrWr |=> cnt0 == '0);  // R5

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cycEn && !busWe |=> $stable(cntFlat));  // R6

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    irq && !busWe |=> $stable(cntFlat));  // R8

  AST_IRQ_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> cnt0 == '0);  // R8

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl0ClrWr |=> !irq);  // R8
endmodule

bind mc_perf_unit mpu_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NC(mpu_pkg::MPU_NCTR)) uChk (
  .clk(clk), .rstN(rstN), .irq(irq), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .cntFlat(cntFlat), .cycEn(cycEn)
);

// File: tb/sim_mc_perf_unit.sv
`timescale 1ns/1ps
module sim_mc_perf_unit;
  localparam int CW = 10;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic busRe = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [255:0] evtPulse = '0;
  logic [15:0] rdId = '0;
  logic [15:0] wrId = '0;
  logic irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mc_perf_unit #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtPulse(evtPulse), .rdId(rdId),
    .wrId(wrId), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busRe = 1'b1; busAddr = a;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic pulse(input int code, input logic [15:0] r, input logic [15:0] w);
    evtPulse[code] = 1'b1; rdId = r; wrId = w;
    @(negedge clk);
    evtPulse[code] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int n = 0; n < 4; n++) begin
      rd(8'(4 * n), v); chk("R1 ctrl after reset", v, 0);
      rd(8'(32 + 4 * n), v); chk("R1 count after reset", v, 0);
    end
    rd(8'h30, v); chk("R1 filter after reset", v, 0);
    chk("R1 irq after reset", 32'(irq), 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(8'h08, 32'h2300_0006);
    rd(8'h08, v); chk("R2 ctrl readback, clear reads 0", v, 32'h2300_0004);
    wr(8'h08, 32'h0);
    wr(8'h30, 32'hFF00_1234);
    rd(8'h30, v); chk("R2 filter readback", v, 32'hFF00_1234);
  endtask

  task automatic t_cycle();
    logic [31:0] v;
    wr(8'h00, 0); wr(8'h00, 32'h6);
    repeat (9) @(negedge clk);
    wr(8'h00, 0);
    rd(8'h20, v); chk("R3 cycle count over window", v, 10);
    wr(8'h00, 32'h4);
    repeat (4) @(negedge clk);
    wr(8'h00, 0);
    rd(8'h20, v); chk("R6 cycle counter resumes from held value", v, 15);
  endtask

  task automatic t_events();
    logic [31:0] v;
    wr(8'h00, 0);
    wr(8'h04, 32'h0500_0006);
    wr(8'h08, 32'h0000_0006);
    wr(8'h0C, 32'h2300_0002);
    wr(8'h00, 32'h6);
    repeat (3) pulse(5, 0, 0);
    repeat (2) pulse(8'h23, 0, 0);
    pulse(0, 0, 0);
    rd(8'h24, v); chk("R4 selected code counted", v, 3);
    rd(8'h28, v); chk("R4 code 0x00 counts nothing", v, 0);
    rd(8'h2C, v); chk("R4 disabled counter holds", v, 0);
    wr(8'h00, 0);
    repeat (2) pulse(5, 0, 0);
    rd(8'h24, v); chk("R6 global stop holds counter 1", v, 3);
    wr(8'h04, 32'h0500_0006);
    rd(8'h24, v); chk("R5 clear zeroes counter", v, 0);
  endtask

  task automatic t_filter();
    logic [31:0] v;
    wr(8'h00, 0);
    wr(8'h30, 32'hFF00_1234);
    wr(8'h04, 32'h4100_0006);
    wr(8'h08, 32'h4200_0006);
    wr(8'h0C, 32'h2300_0006);
    wr(8'h00, 32'h6);
    pulse(8'h41, 16'h1234, 0);
    pulse(8'h41, 16'h5634, 0);
    pulse(8'h41, 16'h1235, 0);
    pulse(8'h42, 16'h1235, 16'hAA34);
    pulse(8'h42, 16'h1234, 16'h0000);
    pulse(8'h23, 16'h1235, 16'h0000);
    pulse(8'h23, 16'hFFFF, 16'hFFFF);
    rd(8'h24, v); chk("R9 read ID filter", v, 2);
    rd(8'h28, v); chk("R9 write ID filter", v, 1);
    rd(8'h2C, v); chk("R10 unfiltered code ignores IDs", v, 2);
    wr(8'h30, 32'hFFFF_0000);
    wr(8'h04, 32'h4100_0006);
    pulse(8'h41, 16'hBEEF, 0);
    rd(8'h24, v); chk("R9 all don't-care mask passes", v, 1);
    wr(8'h00, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(8'h04, 0); wr(8'h0C, 0);
    wr(8'h08, 32'h0700_0006);
    evtPulse[7] = 1'b1;
    wr(8'h00, 32'h6);
    repeat (499) @(negedge clk);
    wr(8'h00, 32'h6);
    repeat (499) @(negedge clk);
    wr(8'h00, 32'h6);
    repeat (99) @(negedge clk);
    wr(8'h00, 0);
    evtPulse[7] = 1'b0;
    rd(8'h28, v); chk("R7 event counter wrapped and kept counting", v, 76);
    rd(8'h08, v); chk("R7 overflow flag of counter 2", v, 32'h0700_0005);
    chk("R7 no irq on event wrap", 32'(irq), 0);
    rd(8'h20, v); chk("R3 cycle count after clear", v, 100);
  endtask

  task automatic t_freeze();
    logic [31:0] v;
    wr(8'h00, 0); wr(8'h08, 0);
    wr(8'h04, 32'h0500_0006);
    wr(8'h00, 32'h6);
    for (int i = 0; i < 1200; i++) begin
      evtPulse[5] = (i % 2 == 0);
      @(negedge clk);
    end
    evtPulse[5] = 1'b0;
    chk("R8 irq after cycle wrap", 32'(irq), 1);
    rd(8'h20, v); chk("R8 cycle counter frozen at 0", v, 0);
    rd(8'h24, v); chk("R8 event counter frozen", v, 512);
    rd(8'h00, v); chk("R8 cycle overflow flag", v, 32'h0000_0005);
    pulse(5, 0, 0);
    rd(8'h24, v); chk("R8 no count while frozen", v, 512);
    wr(8'h00, 32'h4);
    chk("R8 irq drops on rewrite", 32'(irq), 0);
    pulse(5, 0, 0);
    wr(8'h00, 0);
    rd(8'h24, v); chk("R8 counting resumes", v, 513);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_cycle();
    t_events();
    t_filter();
    t_wrap();
    t_freeze();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule